// File: doc/BRIEF.md
# PRBS Link Test Generator and Checker

This block exercises a serial link with pseudo-random traffic and measures how many bits arrive corrupted. The generator side emits a stream from one of three linear-feedback sequences, a whole parallel word per clock. The checker side takes parallel words, normally the same traffic after it has been looped back through the link. It locks onto the selected sequence without being told where the sequence starts, and then counts every bit that differs from the expected value.

Either side can invert its data. This corrects for a differential pair that was swapped on the board, without any change to the hardware. The error total sits in a saturating counter, which a synchronous input clears. An alarm output rises while the total is above a programmable limit. Serialisation, line drivers and clock recovery are outside the block. Everything runs on parallel words in one clock domain.

Top module: `prbs_link_test`

## Requirements
- R1: `pat_sel` chooses the sequence, where each bit obeys b[n] = b[n-A] xor b[n-B]: code 0 gives A=7, B=6; code 1 gives A=23, B=18; codes 2 and 3 give A=31, B=28. After reset or a select change, the history starts as all ones. Bit `WORD_W-1` of a word is the earliest in time. Word k of the sequence appears on `tx_data` after the (k+1)-th clock edge that follows reset release or the select change.
- R2: While `tx_invert` is 1, every bit of `tx_data` is the complement of the sequence bit.
- R3: While `rx_invert` is 1, `rx_data` is complemented before it is checked. With the same setting on both sides, an inverted loopback locks and counts no errors.
- R4: While unlocked, the checker builds its history from the received bits. `locked` rises after the 16th consecutive word in which no bit differs from its prediction. After a reset with all-zero input words, `locked` is 0 after 15 edges and 1 after 16 edges.
- R5: Each received bit that differs from the expected bit adds one to `err_count`, but only while locked. Once locked, the checker predicts from its own history, so a single flipped bit adds exactly 1. While unlocked, the count does not change.
- R6: `err_count` saturates at 2^CNT_W-1 and stays there while errors continue.
- R7: `cnt_clear` = 1 makes `err_count` zero at the next edge, and it wins over errors arriving in the same cycle.
- R8: `err_alarm` is 1 exactly when `err_count` is greater than `err_threshold`.
- R9: A change of `pat_sel` restarts the generator at word 0 of the new sequence and drops `locked`. It leaves `err_count` unchanged.
- R10: While reset is held, `tx_data` is zero, `locked` is 0, `err_count` is 0 and `err_alarm` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 2 | Sequence select |
| tx_invert | input | 1 | Complement outgoing words |
| rx_invert | input | 1 | Complement incoming words |
| tx_data | output | WORD_W | Generated word |
| rx_data | input | WORD_W | Received word, checked every cycle |
| cnt_clear | input | 1 | Synchronous clear of the error count |
| err_threshold | input | CNT_W | Alarm limit |
| err_count | output | CNT_W | Saturating bit-error total |
| locked | output | 1 | Checker is synchronised |
| err_alarm | output | 1 | Count above limit |

## Verification
The properties assume that `pat_sel` behaves as an ordinary synchronous input, so that a difference from the previous cycle marks a restart. They also assume that `rx_data` may carry arbitrary words, including ones that will never lock. The bench therefore changes every input half a period away from the sampling edge. It holds the select steady inside each run, so that a restart happens only where the test intends one. It feeds the checker either the looped-back words with a chosen error mask or a deliberately constant stream.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int HIST_W = 31;

    typedef logic [HIST_W-1:0] hist_t;

    typedef enum logic [1:0] {
        PAT_S7  = 2'd0,
        PAT_S23 = 2'd1,
        PAT_S31 = 2'd2,
        PAT_S31B = 2'd3
    } pat_e;

    localparam hist_t SEED_HIST = '1;

    // next sequence bit from the history, newest bit in position 0
    function automatic logic tap_bit(hist_t h, pat_e p);
        case (p)
            PAT_S7:  return h[6] ^ h[5];
            PAT_S23: return h[22] ^ h[17];
            default: return h[30] ^ h[27];
        endcase
    endfunction

    function automatic hist_t push_bit(hist_t h, logic b);
        return {h[HIST_W-2:0], b};
    endfunction

endpackage

// File: rtl/prbs_word_step.sv
module prbs_word_step
    import prbs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  hist_t             hist_in,
    input  pat_e              pat,
    input  logic [WORD_W-1:0] rx_bits,
    input  logic              follow_rx,
    output logic [WORD_W-1:0] exp_bits,
    output logic [WORD_W-1:0] mism,
    output hist_t             hist_out
);

    always_comb begin
        hist_t h;
        logic  p;
        h        = hist_in;
        exp_bits = '0;
        mism     = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            p           = tap_bit(h, pat);
            exp_bits[i] = p;
            mism[i]     = p ^ rx_bits[i];
            h           = push_bit(h, follow_rx ? rx_bits[i] : p);
        end
        hist_out = h;
    end

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  pat_e              pat,
    input  logic              restart,
    input  logic              invert,
    output logic [WORD_W-1:0] word_out
);

    hist_t             state_q;
    hist_t             state_start;
    hist_t             state_nxt;
    logic [WORD_W-1:0] seq_bits;
    logic [WORD_W-1:0] unused_mism;

    assign state_start = restart ? SEED_HIST : state_q;

    prbs_word_step #(.WORD_W(WORD_W)) u_step (
        .hist_in   (state_start),
        .pat       (pat),
        .rx_bits   ('0),
        .follow_rx (1'b0),
        .exp_bits  (seq_bits),
        .mism      (unused_mism),
        .hist_out  (state_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEED_HIST;
            word_out <= '0;
        end else begin
            state_q  <= state_nxt;
            word_out <= seq_bits ^ {WORD_W{invert}};
        end
    end

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_pkg::*;
#(
    parameter int WORD_W     = 10,
    parameter int LOCK_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  pat_e              pat,
    input  logic              restart,
    input  logic              invert,
    input  logic [WORD_W-1:0] word_in,
    output logic              locked,
    output logic [WORD_W-1:0] hit_bits
);

    localparam int RUN_W = $clog2(LOCK_WORDS + 1);

    typedef struct packed {
        logic             locked;
        logic [RUN_W-1:0] run;
    } sync_t;

    sync_t             sync_q;
    hist_t             hist_q;
    hist_t             hist_nxt;
    logic [WORD_W-1:0] rx_fixed;
    logic [WORD_W-1:0] predicted;
    logic [WORD_W-1:0] mism;
    logic              word_clean;

    assign rx_fixed   = word_in ^ {WORD_W{invert}};
    assign word_clean = (mism == '0);

    prbs_word_step #(.WORD_W(WORD_W)) u_step (
        .hist_in   (hist_q),
        .pat       (pat),
        .rx_bits   (rx_fixed),
        .follow_rx (!sync_q.locked),
        .exp_bits  (predicted),
        .mism      (mism),
        .hist_out  (hist_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            sync_q <= '0;
        end else begin
            hist_q <= hist_nxt;
            if (restart) begin
                sync_q <= '0;
            end else if (!sync_q.locked) begin
                if (!word_clean) begin
                    sync_q.run <= '0;
                end else if (sync_q.run == RUN_W'(LOCK_WORDS - 1)) begin
                    sync_q.locked <= 1'b1;
                    sync_q.run    <= '0;
                end else begin
                    sync_q.run <= sync_q.run + 1'b1;
                end
            end
        end
    end

    assign locked   = sync_q.locked;
    assign hit_bits = (sync_q.locked && !restart) ? mism : '0;

endmodule

// File: rtl/prbs_errcnt.sv
module prbs_errcnt #(
    parameter int WORD_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [WORD_W-1:0] hits,
    output logic [CNT_W-1:0]  count
);

    localparam int ADD_W = $clog2(WORD_W + 1);

    logic [ADD_W-1:0] add;
    logic [CNT_W:0]   sum;

    always_comb begin
        add = '0;
        for (int i = 0; i < WORD_W; i++) begin
            add = add + ADD_W'(hits[i]);
        end
    end

    assign sum = {1'b0, count} + (CNT_W + 1)'(add);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (sum[CNT_W]) begin
            count <= '1;
        end else begin
            count <= sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/prbs_link_test.sv
module prbs_link_test
    import prbs_pkg::*;
#(
    parameter int WORD_W     = 10,
    parameter int CNT_W      = 16,
    parameter int LOCK_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        pat_sel,
    input  logic              tx_invert,
    input  logic              rx_invert,
    output logic [WORD_W-1:0] tx_data,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              cnt_clear,
    input  logic [CNT_W-1:0]  err_threshold,
    output logic [CNT_W-1:0]  err_count,
    output logic              locked,
    output logic              err_alarm
);

    pat_e              pat;
    pat_e              pat_q;
    logic              restart;
    logic [WORD_W-1:0] hits;

    assign pat     = pat_e'(pat_sel);
    assign restart = (pat != pat_q);

    always_ff @(posedge clk) begin
        pat_q <= pat;
    end

    prbs_gen #(.WORD_W(WORD_W)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .pat      (pat),
        .restart  (restart),
        .invert   (tx_invert),
        .word_out (tx_data)
    );

    prbs_chk #(.WORD_W(WORD_W), .LOCK_WORDS(LOCK_WORDS)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .pat      (pat),
        .restart  (restart),
        .invert   (rx_invert),
        .word_in  (rx_data),
        .locked   (locked),
        .hit_bits (hits)
    );

    prbs_errcnt #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .hits  (hits),
        .count (err_count)
    );

    assign err_alarm = (err_count > err_threshold);

endmodule

// File: rtl/prbs_link_test_chk.sv
module prbs_link_test_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       pat_sel,
    input logic             cnt_clear,
    input logic [CNT_W-1:0] err_count,
    input logic             locked,
    input logic             err_alarm
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R5
    unlocked_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && !cnt_clear) |=> $stable(err_count));

    // R6
    count_saturates_chk: assert property (@(posedge clk) disable iff (rst)
        (err_count == CNT_MAX && !cnt_clear) |=> (err_count == CNT_MAX));

    // R6
    count_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_clear |=> (err_count >= $past(err_count)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clear |=> (err_count == '0));

    // R8
    alarm_needs_errors_chk: assert property (@(posedge clk) disable iff (rst)
        err_alarm |-> (err_count != '0));

    // R9
    select_change_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_sel != $past(pat_sel)) |=> !locked);

    // R4
    lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && pat_sel == $past(pat_sel)) |=> locked);

endmodule

bind prbs_link_test prbs_link_test_chk #(.CNT_W(CNT_W)) u_prop_chk (
    .clk       (clk),
    .rst       (rst),
    .pat_sel   (pat_sel),
    .cnt_clear (cnt_clear),
    .err_count (err_count),
    .locked    (locked),
    .err_alarm (err_alarm)
);

// File: tb/prbs_link_test_test.sv
`timescale 1ns/1ps
module prbs_link_test_test;

    localparam int W = 10;
    localparam int CW = 16;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    pat_sel = 2'd0;
    logic          tx_invert = 1'b0;
    logic          rx_invert = 1'b0;
    logic [W-1:0]  tx_data;
    logic [W-1:0]  rx_data;
    logic          cnt_clear = 1'b0;
    logic [CW-1:0] err_threshold = '0;
    logic [CW-1:0] err_count;
    logic          locked;
    logic          err_alarm;

    logic          feed_zero = 1'b0;
    logic [W-1:0]  inj_mask = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign rx_data = feed_zero ? '0 : (tx_data ^ inj_mask);

    prbs_link_test #(.WORD_W(W), .CNT_W(CW), .LOCK_WORDS(16)) uut (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .tx_invert(tx_invert),
        .rx_invert(rx_invert), .tx_data(tx_data), .rx_data(rx_data),
        .cnt_clear(cnt_clear), .err_threshold(err_threshold),
        .err_count(err_count), .locked(locked), .err_alarm(err_alarm)
    );

    // {sel[1:0], tx_invert, rx_invert, expected lock}
    localparam logic [4:0] VEC [8] = '{
        5'b00_0_0_1, 5'b01_0_0_1, 5'b10_0_0_1, 5'b11_1_1_1,
        5'b00_1_0_0, 5'b01_0_1_0, 5'b10_1_1_1, 5'b00_1_1_1
    };

    function automatic logic [W-1:0] ref_word(int sel, int k);
        logic [30:0] h = '1;
        logic [W-1:0] w = '0;
        logic nb;
        int a = (sel == 0) ? 7 : (sel == 1) ? 23 : 31;
        int b = (sel == 0) ? 6 : (sel == 1) ? 18 : 28;
        for (int n = 0; n <= k; n++) begin
            for (int i = W - 1; i >= 0; i--) begin
                nb = h[a-1] ^ h[b-1];
                w[i] = nb;
                h = {h[29:0], nb};
            end
        end
        return w;
    endfunction

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [CW-1:0] c0;
        // R10: state while reset held
        step(2);
        check(tx_data == '0, "R10 tx", tx_data, 0);
        check(!locked, "R10 locked", locked, 0);
        check(err_count == '0, "R10 count", err_count, 0);
        check(!err_alarm, "R10 alarm", err_alarm, 0);

        // R1 R2 R3 R5: table of loopback runs
        for (int v = 0; v < 8; v++) begin
            logic [4:0] e = VEC[v];
            pat_sel = e[4:3];
            tx_invert = e[2];
            rx_invert = e[1];
            do_reset();
            for (int k = 0; k < 6; k++) begin
                step();
                check(tx_data == (ref_word(int'(e[4:3]), k) ^ {W{e[2]}}),
                      "R1/R2 word", tx_data, ref_word(int'(e[4:3]), k) ^ {W{e[2]}});
            end
            step(40);
            check(locked == e[0], "R3/R4 lock", locked, e[0]);
            check(err_count == '0, "R5 count", err_count, 0);
        end

        // R4: exact lock point on a constant stream
        tx_invert = 1'b0;
        rx_invert = 1'b0;
        pat_sel = 2'd0;
        feed_zero = 1'b1;
        do_reset();
        step(15);
        check(!locked, "R4 after 15", locked, 0);
        step();
        check(locked, "R4 after 16", locked, 1);
        feed_zero = 1'b0;

        // R9: select change restarts generator, drops lock, keeps count
        do_reset();
        step(40);
        check(locked, "R9 pre lock", locked, 1);
        inj_mask = 10'b0000100000;
        step();
        inj_mask = '0;
        check(err_count == 1, "R5 single bit", err_count, 1);
        step(5);
        check(err_count == 1, "R5 no spread", err_count, 1);
        pat_sel = 2'd1;
        step();
        check(tx_data == ref_word(1, 0), "R9 word0", tx_data, ref_word(1, 0));
        check(!locked, "R9 unlock", locked, 0);
        check(err_count == 1, "R9 count kept", err_count, 1);
        step();
        check(tx_data == ref_word(1, 1), "R9 word1", tx_data, ref_word(1, 1));
        step(40);
        check(locked, "R9 relock", locked, 1);
        check(err_count == 1, "R5 unlocked ignored", err_count, 1);

        // R8: threshold alarm
        err_threshold = 16'd3;
        inj_mask = 10'b1000000001;
        step();
        inj_mask = '0;
        check(err_count == 3, "R5 two bits", err_count, 3);
        check(!err_alarm, "R8 at limit", err_alarm, 0);
        inj_mask = 10'b0000010000;
        step();
        inj_mask = '0;
        check(err_count == 4, "R5 one bit", err_count, 4);
        check(err_alarm, "R8 above limit", err_alarm, 1);

        // R7: clear
        cnt_clear = 1'b1;
        step();
        cnt_clear = 1'b0;
        check(err_count == '0, "R7 clear", err_count, 0);
        check(!err_alarm, "R8 cleared", err_alarm, 0);

        // R3 R6: flipping rx polarity while locked gives a full word of errors
        rx_invert = 1'b1;
        step();
        check(err_count == 10, "R3 inverted word", err_count, 10);
        step(6600);
        check(err_count == CMAX, "R6 saturate", err_count, CMAX);
        step(3);
        check(err_count == CMAX, "R6 stays", err_count, CMAX);
        err_threshold = 16'd100;
        check(err_alarm, "R8 saturated", err_alarm, 1);

        // R7: clear beats simultaneous errors
        cnt_clear = 1'b1;
        step();
        cnt_clear = 1'b0;
        check(err_count == '0, "R7 priority", err_count, 0);
        step();
        check(err_count == 10, "R7 resume", err_count, 10);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule